// File: doc/BRIEF.md
# Single-Word Slot Mailbox Bank

This block is a one-way mailbox between two agents that share one clock. It holds a bank of single-word slots. The producer side has a write-only register port. Each producer write to a slot address stores the word and raises a pending flag for that slot. The consumer side has a register port of its own. Through it the consumer reads a status word that shows every pending flag, programs an arm (enable) mask, and acknowledges flags through a write-one-to-clear register. It then reads the stored word back from the slot address.

The consumer gets one combined interrupt line. It is asserted while any pending flag is also armed. The producer side has no interrupt at all. The slot count, the data and address widths, the bit position of the flag field and every register address are parameters. By default there are eight 32-bit slots on an 8-bit byte address.

Top module: `fast_slot_mbox`

## Requirements
- R1: After a synchronous reset, `rcv_irq` is low, `rcv_rvalid` is low, and the status word, the arm mask and every slot all read as zero.
- R2: A producer write to slot n (byte address 0x8C + 4·n, n = 0..7) stores the 32-bit word. A later consumer read of that same address returns it.
- R3: A producer write to slot n sets bit (n + 9) of the status word, read at 0xC8, and leaves every other bit unchanged. Bits outside 9..16 always read as zero.
- R4: A consumer write to the clear register at 0xC4 clears each status bit whose data bit is 1 and leaves the bits written as 0 unchanged. The clear register reads as zero.
- R5: The arm mask at 0xC0 keeps only bits 9..16 of a consumer write and reads back with all other bits zero. `rcv_irq` is a register that takes the OR of (status AND arm) one clock after those registers change.
- R6: A producer write to a slot whose flag is still pending overwrites the stored word, and the flag stays set.
- R7: When a producer write to slot n and a consumer clear write hitting bit (n + 9) arrive in the same cycle, the flag ends up set. Other bits named by that clear write are still cleared.
- R8: A producer write to any address that is not a slot address changes no state. A consumer write to a slot address or to the status address changes no state.
- R9: Read data appears on `rcv_rdata` with `rcv_rvalid` high in the cycle after `rcv_rd_en`. `rcv_rvalid` is low in every other cycle, and a read of an address that maps to no register returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous reset, active high |
| snd_wr_en | input | 1 | Producer write strobe |
| snd_addr | input | 8 | Producer byte address |
| snd_wdata | input | 32 | Producer write data |
| rcv_wr_en | input | 1 | Consumer write strobe |
| rcv_rd_en | input | 1 | Consumer read strobe |
| rcv_addr | input | 8 | Consumer byte address (reads and writes) |
| rcv_wdata | input | 32 | Consumer write data |
| rcv_rdata | output | 32 | Registered consumer read data |
| rcv_rvalid | output | 1 | High in the cycle `rcv_rdata` is valid |
| rcv_irq | output | 1 | Registered combined consumer interrupt |

## Verification
A flag lost or set wrongly shows up two ways. A status read taken one cycle later returns the wrong bit. `rcv_irq` goes wrong one clock after that, provided the slot is armed. A clear or arm decode that hits the wrong address shows up only when the affected register is next read back, so the bench reads status and arm after each stimulus that could touch them. A write-enable or index fault in the slot storage stays hidden until that slot is read. For that reason every slot is read back, including after a consumer write that must not reach it.

// File: rtl/fsmb_pkg.sv
package fsmb_pkg;

  // Source the consumer read port selects for the registered read data.
  typedef enum logic [1:0] {
    RSEL_NONE,
    RSEL_SLOT,
    RSEL_ARM,
    RSEL_STATUS
  } rsel_e;

  localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/fsmb_slot_decode.sv
module fsmb_slot_decode
  import fsmb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_SLOTS = 8,
  parameter logic [ADDR_W-1:0] SLOT_BASE = 'h8C,
  localparam int unsigned IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic                 hit,
  output logic [IDX_W-1:0]     idx,
  output logic [NUM_SLOTS-1:0] onehot
);

  // One comparator per slot, each against its own word address.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
    localparam logic [ADDR_W-1:0] SLOT_ADDR =
      SLOT_BASE + ADDR_W'(WORD_BYTES * s);
    assign onehot[s] = (addr == SLOT_ADDR);
  end

  always_comb begin
    idx = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (onehot[s]) idx = IDX_W'(s);
    end
  end

  assign hit = |onehot;

endmodule

// File: rtl/fsmb_slot_store.sv
module fsmb_slot_store #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_SLOTS = 8,
  localparam int unsigned IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rword
);

  logic [DATA_W-1:0] slot_w [NUM_SLOTS];

  // Each slot is its own resettable register, so reset clears it.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (we && (widx == IDX_W'(s))) begin
        q <= wdata;
      end
    end
    assign slot_w[s] = q;
  end

  assign rword = slot_w[ridx];

endmodule

// File: rtl/fsmb_flag_ctrl.sv
module fsmb_flag_ctrl #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned STAT_OFS  = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLOTS-1:0] set_vec,
  input  logic                 clr_we,
  input  logic                 arm_we,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    status_word,
  output logic [DATA_W-1:0]    arm_word,
  output logic                 irq_q
);

  logic [NUM_SLOTS-1:0] pend_q, arm_q, clr_field, pend_d;

  assign clr_field = clr_we ? wdata[STAT_OFS +: NUM_SLOTS] : '0;
  // A new message in the same cycle as its acknowledge wins.
  assign pend_d    = (pend_q & ~clr_field) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      arm_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (arm_we) arm_q <= wdata[STAT_OFS +: NUM_SLOTS];
      irq_q  <= |(pend_q & arm_q);
    end
  end

  assign status_word = DATA_W'(pend_q) << STAT_OFS;
  assign arm_word    = DATA_W'(arm_q) << STAT_OFS;

endmodule

// File: rtl/fast_slot_mbox.sv
module fast_slot_mbox
  import fsmb_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned STAT_OFS  = 9,
  parameter logic [ADDR_W-1:0] SLOT_BASE = 'h8C,
  parameter logic [ADDR_W-1:0] ARM_ADDR  = 'hC0,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 'hC4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'hC8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snd_wr_en,
  input  logic [ADDR_W-1:0] snd_addr,
  input  logic [DATA_W-1:0] snd_wdata,
  input  logic              rcv_wr_en,
  input  logic              rcv_rd_en,
  input  logic [ADDR_W-1:0] rcv_addr,
  input  logic [DATA_W-1:0] rcv_wdata,
  output logic [DATA_W-1:0] rcv_rdata,
  output logic              rcv_rvalid,
  output logic              rcv_irq
);

  localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic                 snd_hit, rcv_hit;
  logic [IDX_W-1:0]     snd_idx, rcv_idx;
  logic [NUM_SLOTS-1:0] snd_onehot, rcv_onehot, set_vec;
  logic [DATA_W-1:0]    slot_word, status_word, arm_word;
  logic                 arm_we, clr_we;
  rsel_e                rsel;

  fsmb_slot_decode #(
    .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_BASE(SLOT_BASE)
  ) snd_dec_i (
    .addr(snd_addr), .hit(snd_hit), .idx(snd_idx), .onehot(snd_onehot)
  );

  fsmb_slot_decode #(
    .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_BASE(SLOT_BASE)
  ) rcv_dec_i (
    .addr(rcv_addr), .hit(rcv_hit), .idx(rcv_idx), .onehot(rcv_onehot)
  );

  fsmb_slot_store #(
    .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS)
  ) store_i (
    .clk(clk), .rst(rst),
    .we(snd_wr_en && snd_hit), .widx(snd_idx), .wdata(snd_wdata),
    .ridx(rcv_idx), .rword(slot_word)
  );

  assign set_vec = snd_wr_en ? snd_onehot : '0;
  assign arm_we  = rcv_wr_en && (rcv_addr == ARM_ADDR);
  assign clr_we  = rcv_wr_en && (rcv_addr == CLR_ADDR);

  fsmb_flag_ctrl #(
    .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .STAT_OFS(STAT_OFS)
  ) flags_i (
    .clk(clk), .rst(rst), .set_vec(set_vec),
    .clr_we(clr_we), .arm_we(arm_we), .wdata(rcv_wdata),
    .status_word(status_word), .arm_word(arm_word), .irq_q(rcv_irq)
  );

  always_comb begin
    if (rcv_hit)                     rsel = RSEL_SLOT;
    else if (rcv_addr == ARM_ADDR)   rsel = RSEL_ARM;
    else if (rcv_addr == STAT_ADDR)  rsel = RSEL_STATUS;
    else                             rsel = RSEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rcv_rdata  <= '0;
      rcv_rvalid <= 1'b0;
    end else begin
      rcv_rvalid <= rcv_rd_en;
      if (rcv_rd_en) begin
        case (rsel)
          RSEL_SLOT:   rcv_rdata <= slot_word;
          RSEL_ARM:    rcv_rdata <= arm_word;
          RSEL_STATUS: rcv_rdata <= status_word;
          default:     rcv_rdata <= '0;
        endcase
      end
    end
  end

  // Unused decode output of the consumer decoder.
  logic unused_ok;
  assign unused_ok = ^rcv_onehot;

endmodule

// File: rtl/fast_slot_mbox_chk.sv
module fast_slot_mbox_chk #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned STAT_OFS  = 9,
  parameter logic [ADDR_W-1:0] SLOT_BASE = 'h8C,
  parameter logic [ADDR_W-1:0] ARM_ADDR  = 'hC0,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 'hC4
) (
  input logic              clk,
  input logic              rst,
  input logic              snd_wr_en,
  input logic [ADDR_W-1:0] snd_addr,
  input logic              rcv_wr_en,
  input logic              rcv_rd_en,
  input logic [ADDR_W-1:0] rcv_addr,
  input logic [DATA_W-1:0] rcv_wdata,
  input logic              rcv_rvalid,
  input logic              rcv_irq,
  input logic [DATA_W-1:0] status_word,
  input logic [DATA_W-1:0] arm_word
);

  // Independent arithmetic decode of the producer address.
  logic [ADDR_W-1:0] snd_off;
  logic              snd_slot;
  int unsigned       snd_bit;
  logic              clr_wr, arm_wr;

  assign snd_off  = snd_addr - SLOT_BASE;
  assign snd_slot = snd_wr_en && (snd_addr >= SLOT_BASE) && (snd_off[1:0] == 2'b00)
                    && (int'(snd_off >> 2) < int'(NUM_SLOTS));
  assign snd_bit  = STAT_OFS + int'(snd_off >> 2);
  assign clr_wr   = rcv_wr_en && (rcv_addr == CLR_ADDR);
  assign arm_wr   = rcv_wr_en && (rcv_addr == ARM_ADDR);

  p_flag_set_r3: assert property (@(posedge clk) disable iff (rst)
    snd_slot |=> status_word[$past(snd_bit)]);

  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !snd_slot) |=> ((status_word & $past(rcv_wdata)) == '0));

  p_status_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!snd_slot && !clr_wr) |=> $stable(status_word));

  p_arm_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !arm_wr |=> $stable(arm_word));

  p_irq_lag_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rcv_irq == |($past(status_word) & $past(arm_word))));

  p_rvalid_on_r9: assert property (@(posedge clk) disable iff (rst)
    rcv_rd_en |=> rcv_rvalid);

  p_rvalid_off_r9: assert property (@(posedge clk) disable iff (rst)
    !rcv_rd_en |=> !rcv_rvalid);

endmodule

bind fast_slot_mbox fast_slot_mbox_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .STAT_OFS(STAT_OFS),
  .SLOT_BASE(SLOT_BASE), .ARM_ADDR(ARM_ADDR), .CLR_ADDR(CLR_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .snd_wr_en(snd_wr_en), .snd_addr(snd_addr),
  .rcv_wr_en(rcv_wr_en), .rcv_rd_en(rcv_rd_en), .rcv_addr(rcv_addr),
  .rcv_wdata(rcv_wdata), .rcv_rvalid(rcv_rvalid), .rcv_irq(rcv_irq),
  .status_word(status_word), .arm_word(arm_word)
);

// File: tb/fast_slot_mbox_tb_top.sv
module fast_slot_mbox_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_SLOT0 = 8'h8C;
  localparam logic [7:0] A_ARM   = 8'hC0;
  localparam logic [7:0] A_CLR   = 8'hC4;
  localparam logic [7:0] A_STAT  = 8'hC8;
  localparam logic [31:0] ALL_FLAGS = 32'h0001_FE00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        snd_wr_en = 1'b0;
  logic [7:0]  snd_addr = '0;
  logic [31:0] snd_wdata = '0;
  logic        rcv_wr_en = 1'b0;
  logic        rcv_rd_en = 1'b0;
  logic [7:0]  rcv_addr = '0;
  logic [31:0] rcv_wdata = '0;
  logic [31:0] rcv_rdata;
  logic        rcv_rvalid;
  logic        rcv_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fast_slot_mbox dut_i (
    .clk(clk), .rst(rst),
    .snd_wr_en(snd_wr_en), .snd_addr(snd_addr), .snd_wdata(snd_wdata),
    .rcv_wr_en(rcv_wr_en), .rcv_rd_en(rcv_rd_en), .rcv_addr(rcv_addr),
    .rcv_wdata(rcv_wdata), .rcv_rdata(rcv_rdata), .rcv_rvalid(rcv_rvalid),
    .rcv_irq(rcv_irq)
  );

  function automatic logic [31:0] slot_val(int n);
    return 32'h1000_0000 + 32'(n) * 32'h0011_1111;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read results as the design returns them.
  always @(negedge clk) begin
    if (!rst && rcv_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R9 rvalid without a pending read", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), rcv_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic snd_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    snd_wr_en = 1'b1; snd_addr = a; snd_wdata = d;
    @(negedge clk);
    snd_wr_en = 1'b0;
  endtask

  task automatic rcv_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    rcv_wr_en = 1'b1; rcv_addr = a; rcv_wdata = d;
    @(negedge clk);
    rcv_wr_en = 1'b0;
  endtask

  task automatic both_wr(input logic [7:0] sa, input logic [31:0] sd,
                         input logic [7:0] ra, input logic [31:0] rd);
    @(negedge clk);
    snd_wr_en = 1'b1; snd_addr = sa; snd_wdata = sd;
    rcv_wr_en = 1'b1; rcv_addr = ra; rcv_wdata = rd;
    @(negedge clk);
    snd_wr_en = 1'b0; rcv_wr_en = 1'b0;
  endtask

  // Driver: pushes the expected item, then issues the read.
  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rcv_rd_en = 1'b1; rcv_addr = a;
    @(negedge clk);
    rcv_rd_en = 1'b0;
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    repeat (2) @(negedge clk);
    check(tag, 32'(rcv_irq), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 irq after reset", 32'(rcv_irq), 32'd0);
    check("R1 rvalid after reset", 32'(rcv_rvalid), 32'd0);
    rd_chk(A_STAT, 32'h0, "R1 status after reset");
    rd_chk(A_ARM, 32'h0, "R1 arm after reset");
    rd_chk(A_SLOT0, 32'h0, "R1 slot0 after reset");
    rd_chk(8'hA8, 32'h0, "R1 slot7 after reset");

    // R2/R3: fill every slot, read each back
    for (int n = 0; n < 8; n++) snd_wr(A_SLOT0 + 8'(4*n), slot_val(n));
    for (int n = 0; n < 8; n++)
      rd_chk(A_SLOT0 + 8'(4*n), slot_val(n), $sformatf("R2 slot%0d readback", n));
    rd_chk(A_STAT, ALL_FLAGS, "R3 all flags set");
    irq_chk(1'b0, "R5 irq low with arm mask zero");

    // R5: arm mask keeps only the flag field
    rcv_wr(A_ARM, 32'hFFFF_FFFF);
    rd_chk(A_ARM, ALL_FLAGS, "R5 arm readback masked");
    irq_chk(1'b1, "R5 irq high when armed and pending");

    // R4: partial clear, zeros leave bits alone
    rcv_wr(A_CLR, ALL_FLAGS & ~(32'h1 << 12));
    rd_chk(A_STAT, 32'h1 << 12, "R4 only slot3 flag remains");
    rd_chk(A_CLR, 32'h0, "R4 clear register reads zero");
    rcv_wr(A_ARM, 32'h0);
    irq_chk(1'b0, "R5 irq low after disarm");
    rcv_wr(A_ARM, 32'h1 << 12);
    irq_chk(1'b1, "R5 irq high after rearm of slot3");
    rcv_wr(A_CLR, 32'h1 << 12);
    rd_chk(A_STAT, 32'h0, "R4 status empty after clear");
    irq_chk(1'b0, "R5 irq low after clear");

    // R6: overwrite while pending
    snd_wr(8'hA0, 32'hAAAA_0001);
    snd_wr(8'hA0, 32'hBBBB_0002);
    rd_chk(A_STAT, 32'h1 << 14, "R6 slot5 flag still single and set");
    rd_chk(8'hA0, 32'hBBBB_0002, "R6 slot5 holds newest word");
    irq_chk(1'b0, "R5 irq low for unarmed slot5");

    // R7: write and clear of same slot collide; another bit still clears
    both_wr(8'h94, 32'hCCCC_0003, A_CLR, (32'h1 << 11) | (32'h1 << 14));
    rd_chk(A_STAT, 32'h1 << 11, "R7 set wins, slot5 cleared");
    rd_chk(8'h94, 32'hCCCC_0003, "R7 slot2 word stored");

    // R8: writes to wrong places are ignored
    snd_wr(A_CLR, 32'hFFFF_FFFF);
    snd_wr(A_ARM, 32'h0);
    snd_wr(8'h88, 32'h1234_5678);
    snd_wr(8'hAC, 32'h1234_5678);
    snd_wr(8'h8D, 32'h1234_5678);
    rd_chk(A_STAT, 32'h1 << 11, "R8 status untouched by stray producer writes");
    rd_chk(A_ARM, 32'h1 << 12, "R8 arm untouched by producer");
    rcv_wr(A_SLOT0, 32'hDEAD_BEEF);
    rcv_wr(A_STAT, 32'hFFFF_FFFF);
    rd_chk(A_SLOT0, slot_val(0), "R8 consumer cannot write slot0");
    rd_chk(A_STAT, 32'h1 << 11, "R8 status read-only");

    // R9: unmapped reads and idle rvalid
    rd_chk(8'h00, 32'h0, "R9 unmapped read zero");
    rd_chk(8'hB0, 32'h0, "R9 unmapped read zero at 0xB0");
    repeat (2) @(negedge clk);
    check("R9 rvalid low when idle", 32'(rcv_rvalid), 32'd0);
    check("R9 all reads answered", 32'(exp_q.size()), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule